// File: doc/BRIEF.md
# Nibble-Serial GHASH Multiplier

This block performs the GHASH update used by GCM authentication. It keeps a 128-bit running state X. For each accepted 128-bit block C it replaces X with (X xor C)·H in GF(2^128). The multiply walks the operand one 4-bit nibble per clock. Each step shifts the accumulator right by four bit positions, adds the key-table entry selected by the current nibble, and folds the four bits that fell off the bottom back into the top 16 bits through a fixed 16-entry reduction table.

The key table is not derived inside the block. Software or a neighbouring key-schedule unit writes the 16 multiples of H through a simple write port. After that, blocks are streamed through a valid/ready handshake, and the state carries over from one block to the next. A mode bit, sampled when a block is accepted, selects a plain multiply X = X·H. In that mode the offered data is ignored.

Top module: `gh_nibble_engine`

## Requirements
- R1: After reset the state output is all zero, `in_ready` is high and `done_o` is low.
- R2: In hash mode (`in_mult_only`=0) an accepted block C replaces the state X with (X xor C)·H. Byte 0 of every 128-bit value is bits [127:120]. The most significant bit of the vector is the x^0 coefficient, and the field polynomial is x^128+x^7+x^2+x+1.
- R3: In multiply mode (`in_mult_only`=1) the state becomes X·H. The value on `in_data` has no effect.
- R4: Table entry k (written with `tbl_we`=1, `tbl_idx`=k, `tbl_data`) must hold the XOR of the following values for each set bit of k: H for bit 3, H·x for bit 2, H·x^2 for bit 1, H·x^3 for bit 0. Entry 0 is zero.
- R5: `done_o` is high for exactly one cycle, 32 clock edges after the accepting edge. The new state is visible on `state_o` in that same cycle.
- R6: `in_ready` is low from the accepting edge until `done_o` rises. A valid block offered in that window is not taken and does not change the result.
- R7: The state carries over between blocks, so a stream of blocks yields the chained GHASH value.
- R8: `state_o` changes only in the cycle in which `done_o` is high.
- R9: A table rewrite made while idle applies to the next accepted block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Key table write strobe |
| tbl_idx | input | 4 | Key table entry index |
| tbl_data | input | 128 | Key table entry value |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Engine idle, block will be taken |
| in_data | input | 128 | Input block |
| in_mult_only | input | 1 | 1: multiply state by H without adding the input |
| state_o | output | 128 | Running GHASH state |
| done_o | output | 1 | One-cycle pulse when a new state is ready |

## Verification
The bench uses the default widths: a 128-bit block, 4-bit nibbles, a 16-entry key table and a 32-step walk. These are the only values for which the reduction constants are defined. With them, random operands reach all 16 key-table entries and all 16 fold indices within a few blocks. Directed cases add a zero key, the field identity as key, rekeying between blocks, and blocks offered while the engine is busy. Expected values come from a bit-serial field multiply in the bench.

// File: rtl/gh_pkg.sv
package gh_pkg;
    localparam int BLK_W    = 128;
    localparam int NIB_W    = 4;
    localparam int TBL_N    = 1 << NIB_W;
    localparam int STEPS    = BLK_W / NIB_W;
    localparam int CNT_W    = $clog2(STEPS);
    localparam int FOLD_W   = 16;
    localparam logic [FOLD_W-1:0] FOLD_BASE = 16'hE100;

    typedef logic [BLK_W-1:0] blk_t;
    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gh_fsm_e;

    typedef struct packed {
        blk_t operand;
        blk_t acc;
        cnt_t step;
    } gh_job_t;

    // Reduction constant for the four bits shifted out of the accumulator.
    function automatic logic [FOLD_W-1:0] fold_val(input nib_t r);
        logic [FOLD_W-1:0] v;
        v = '0;
        for (int b = 0; b < NIB_W; b++) begin
            if (r[b]) v = v ^ (FOLD_BASE >> (NIB_W - 1 - b));
        end
        return v;
    endfunction

    function automatic blk_t shift_fold(input blk_t z, input blk_t t);
        blk_t f;
        f = '0;
        f[BLK_W-1 -: FOLD_W] = fold_val(z[NIB_W-1:0]);
        return (z >> NIB_W) ^ t ^ f;
    endfunction
endpackage

// File: rtl/gh_key_table.sv
module gh_key_table
    import gh_pkg::*;
#(
    parameter int ENTRIES = TBL_N,
    parameter int WIDTH   = BLK_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] entry_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[g] <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                entry_q[g] <= wdata;
            end
        end
    end

    assign rdata = entry_q[ridx];
endmodule

// File: rtl/gh_nibble_pick.sv
module gh_nibble_pick
    import gh_pkg::*;
#(
    parameter int WIDTH  = BLK_W,
    parameter int NW     = NIB_W,
    localparam int COUNT = WIDTH / NW,
    localparam int SEL_W = $clog2(COUNT)
) (
    input  logic [WIDTH-1:0] operand,
    input  logic [SEL_W-1:0] sel,
    output logic [NW-1:0]    nib
);
    // Step s walks byte 15-(s/2), low half first; that is nibble s from the LSB.
    logic [NW-1:0] nibs [COUNT];

    for (genvar g = 0; g < COUNT; g++) begin : g_nib
        assign nibs[g] = operand[g*NW +: NW];
    end

    assign nib = nibs[sel];
endmodule

// File: rtl/gh_step_unit.sv
module gh_step_unit
    import gh_pkg::*;
(
    input  logic first,
    input  blk_t acc,
    input  blk_t entry,
    output blk_t acc_next
);
    always_comb begin
        if (first) acc_next = entry;
        else       acc_next = shift_fold(acc, entry);
    end
endmodule

// File: rtl/gh_nibble_engine.sv
module gh_nibble_engine
    import gh_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         tbl_we,
    input  logic [3:0]   tbl_idx,
    input  logic [127:0] tbl_data,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [127:0] in_data,
    input  logic         in_mult_only,
    output logic [127:0] state_o,
    output logic         done_o
);
    gh_fsm_e fsm_q;
    gh_job_t job_q;
    blk_t    state_q;
    logic    done_q;

    nib_t    cur_nib;
    blk_t    cur_entry;
    blk_t    acc_next;
    logic    last_step;
    logic    accept;

    gh_key_table #(.ENTRIES(TBL_N), .WIDTH(BLK_W)) u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (tbl_we),
        .widx  (tbl_idx),
        .wdata (tbl_data),
        .ridx  (cur_nib),
        .rdata (cur_entry)
    );

    gh_nibble_pick #(.WIDTH(BLK_W), .NW(NIB_W)) u_pick (
        .operand (job_q.operand),
        .sel     (job_q.step),
        .nib     (cur_nib)
    );

    gh_step_unit u_step (
        .first    (job_q.step == '0),
        .acc      (job_q.acc),
        .entry    (cur_entry),
        .acc_next (acc_next)
    );

    assign in_ready  = (fsm_q == ST_IDLE);
    assign accept    = in_valid && in_ready;
    assign last_step = (job_q.step == cnt_t'(STEPS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q   <= ST_IDLE;
            job_q   <= '0;
            state_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (fsm_q)
                ST_IDLE: begin
                    if (accept) begin
                        job_q.operand <= in_mult_only ? state_q : (state_q ^ in_data);
                        job_q.acc     <= '0;
                        job_q.step    <= '0;
                        fsm_q         <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    job_q.acc  <= acc_next;
                    job_q.step <= job_q.step + 1'b1;
                    if (last_step) begin
                        state_q <= acc_next;
                        done_q  <= 1'b1;
                        fsm_q   <= ST_IDLE;
                    end
                end
                default: fsm_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign done_o  = done_q;
endmodule

// File: rtl/gh_engine_chk.sv
module gh_engine_chk
    import gh_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_ready,
    input logic [127:0] state_o,
    input logic         done_o
);
    localparam int LAT_W = $clog2(STEPS + 2) + 1;
    logic [LAT_W-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
        end else if (in_valid && in_ready) begin
            lat_q <= LAT_W'(1);
        end else if (!in_ready) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (lat_q == LAT_W'(STEPS + 1)));                  // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);                                          // R5

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);                        // R6

    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> in_ready);                                         // R6

    AST_STATE_HELD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(state_o));                                // R8
endmodule

bind gh_nibble_engine gh_engine_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .state_o  (state_o),
    .done_o   (done_o)
);

// File: tb/tb_gh_nibble_engine.sv
module tb_gh_nibble_engine;
    logic         clk = 1'b0;
    logic         rst;
    logic         tbl_we;
    logic [3:0]   tbl_idx;
    logic [127:0] tbl_data;
    logic         in_valid;
    logic         in_ready;
    logic [127:0] in_data;
    logic         in_mult_only;
    logic [127:0] state_o;
    logic         done_o;

    int checks = 0;
    int errors = 0;
    logic [127:0] model_x;
    logic [127:0] model_h;

    always #10 clk = ~clk;

    gh_nibble_engine dut (
        .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_data(tbl_data), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_mult_only(in_mult_only),
        .state_o(state_o), .done_o(done_o)
    );

    function automatic logic [127:0] mulx(input logic [127:0] v);
        return v[0] ? ((v >> 1) ^ {8'hE1, 120'b0}) : (v >> 1);
    endfunction

    function automatic logic [127:0] gf_mul(input logic [127:0] a, input logic [127:0] b);
        logic [127:0] z;
        logic [127:0] v;
        z = '0;
        v = b;
        for (int i = 0; i < 128; i++) begin
            if (a[127-i]) z = z ^ v;
            v = mulx(v);
        end
        return z;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // R4: entry k = XOR of H, H.x, H.x^2, H.x^3 for bits 3,2,1,0 of k
    task automatic load_key(input logic [127:0] h);
        logic [127:0] t8, t4, t2, t1;
        t8 = h; t4 = mulx(t8); t2 = mulx(t4); t1 = mulx(t2);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            tbl_we   = 1'b1;
            tbl_idx  = 4'(k);
            tbl_data = (k[3] ? t8 : '0) ^ (k[2] ? t4 : '0) ^
                       (k[1] ? t2 : '0) ^ (k[0] ? t1 : '0);
        end
        @(negedge clk);
        tbl_we = 1'b0;
        model_h = h;
    endtask

    task automatic run_block(input logic [127:0] c, input bit mult, input bit poke_busy,
                             input string req);
        logic [127:0] exp;
        logic [127:0] held;
        int cyc;
        bit seen_busy_ready;
        exp = mult ? gf_mul(model_x, model_h) : gf_mul(model_x ^ c, model_h);
        held = state_o;
        seen_busy_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b1;
        in_data = c;
        in_mult_only = mult;
        @(negedge clk);
        in_valid = 1'b0;
        in_data = rnd128();
        cyc = 1;
        while (!done_o && cyc < 100) begin
            if (in_ready) seen_busy_ready = 1'b1;
            if (poke_busy && cyc >= 4 && cyc < 10) begin
                in_valid = 1'b1;
                in_mult_only = ~mult;
            end else begin
                in_valid = 1'b0;
            end
            if (cyc == 12)
                chk(state_o == held, "R8", "state moved while busy", state_o, held);
            @(negedge clk);
            cyc++;
        end
        in_valid = 1'b0;
        chk(cyc == 33, "R5", "done latency", 128'(cyc), 128'd33);
        chk(!seen_busy_ready, "R6", "ready high while busy", 128'(seen_busy_ready), 128'd0);
        chk(state_o == exp, req, "result", state_o, exp);
        @(negedge clk);
        chk(!done_o, "R5", "done longer than one cycle", 128'(done_o), 128'd0);
        chk(state_o == exp, "R8", "state after done", state_o, exp);
        model_x = exp;
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] h;
        void'($urandom(32'h5EED_0A17));
        rst = 1'b1; tbl_we = 1'b0; tbl_idx = '0; tbl_data = '0;
        in_valid = 1'b0; in_data = '0; in_mult_only = 1'b0;
        model_x = '0; model_h = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(state_o == '0, "R1", "state after reset", state_o, '0);
        chk(in_ready, "R1", "ready after reset", 128'(in_ready), 128'd1);
        chk(!done_o, "R1", "done after reset", 128'(done_o), 128'd0);

        // zero key: any block hashes to zero
        load_key('0);
        run_block(rnd128(), 1'b0, 1'b0, "R2");
        // identity key (x^0 is the vector MSB)
        load_key({1'b1, 127'b0});
        h = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        run_block(h, 1'b0, 1'b0, "R2");
        chk(state_o == h, "R4", "identity key passes block", state_o, h);
        // random key, chained stream mixing modes
        load_key(rnd128());
        for (int i = 0; i < 12; i++)
            run_block(rnd128(), 1'b0, (i % 3) == 1, "R7");
        run_block(rnd128(), 1'b1, 1'b0, "R3");
        run_block('1, 1'b1, 1'b1, "R3");
        // rekey between blocks
        load_key(rnd128());
        run_block(rnd128(), 1'b0, 1'b0, "R9");
        for (int i = 0; i < 20; i++)
            run_block(rnd128(), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R2");
        load_key({8'hFF, 112'b0, 8'h01});
        run_block({16{8'hA5}}, 1'b0, 1'b0, "R9");
        run_block('0, 1'b1, 1'b0, "R3");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule